// File: doc/BRIEF.md
# Reloading Down-Counter with Toggle Output

This block is an 8-bit down-counting timer. Software programs it through a small write port that holds three registers: a reload latch, a mode word and a preset for the output flip-flop. When it runs, the counter steps down once for every falling edge of a chosen count source. The source can be a prescaled clock level, a slow clock level, the overflow level of a neighbouring timer, or an external event pin whose polarity is selectable. All source inputs are treated as asynchronous levels. They are synchronised into the system clock and turned into one-cycle edge strobes.

After the counter wraps from 00 to FF, the next rising edge of the source produces a one-cycle overflow pulse. That pulse is intended for an interrupt controller that latches it. The same rising edge inverts an output flip-flop, so the optional output pin carries a 50% duty square wave at half the overflow rate. The next falling edge reloads the counter with the latch value minus one. A latch value n therefore gives one overflow every n+1 source periods.

The write port is a plain single-cycle strobe with no back-pressure. Every write is accepted in the cycle in which `wr_en` is high. The counter value is brought out on `count_o` so that software can read it.

Top module: `dctr_timer`

## Requirements
- R1: After reset, `count_o` is 00, the reload latch is 00, the timer is stopped, the event polarity and output-enable bits are 0, `tout_o` is 0 and `ovf_irq_o` is 0.
- R2: A write to address 0 stores `wr_data` in the reload latch. If the stop bit is 1 at the time of the write, the counter is loaded with the same value; if the timer is running, the counter is left unchanged.
- R3: While running, each falling edge of the selected source decrements the counter by one, and 00 steps to FF.
- R4: While running, a falling edge that finds the counter at FF loads it with (latch − 1) modulo 256. For a latch value n this gives one overflow per n+1 falling edges, and n = 0 gives one overflow per edge.
- R5: `ovf_irq_o` is high for exactly one clock cycle on the first rising edge of the source after the counter reached FF; `count_o` reads FF during that pulse.
- R6: Address 1 holds the mode word: bit 0 is stop (1 = halted, 0 = counting), bits 2:1 select the source, bit 3 is the event polarity and bit 4 is the output enable. While stop is 1, source edges change neither the counter nor the output flip-flop, and no overflow is raised.
- R7: Each overflow inverts the output flip-flop. `tout_o` equals the flip-flop when the output enable is 1 and is 0 otherwise.
- R8: A write to address 2 sets the output flip-flop to `wr_data[0]` only while the timer is stopped; while running, such a write is ignored.
- R9: Source select encoding: 0 = `src_presc_i`, 1 = `src_slow_i`, 2 = `src_chain_i`, 3 = `evt_pin_i`. Unselected inputs have no effect.
- R10: With source 3, an event polarity bit of 1 counts `evt_pin_i` as it is, and a bit of 0 counts its inverse, so falling edges of the inverted pin step the counter.
- R11: The counter reflects a source falling edge on the second rising clock edge after the input changes, and not on the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 latch, 1 mode, 2 flip-flop preset |
| wr_data | input | 8 | Write data |
| src_presc_i | input | 1 | Prescaled clock level (source 0) |
| src_slow_i | input | 1 | Slow clock level (source 1) |
| src_chain_i | input | 1 | Neighbour timer overflow level (source 2) |
| evt_pin_i | input | 1 | External event pin (source 3) |
| tout_o | output | 1 | Gated toggle output |
| ovf_irq_o | output | 1 | One-cycle overflow request |
| count_o | output | 8 | Current counter value |

## Verification
A corrupted counter or reload path first appears on `count_o`, at the very next source falling edge. A wrong reload value also moves the spacing between overflow pulses, and the bench sees that within one n+1 period. A lost or doubled overflow shows two ways: the pulse count over a sweep differs from the count computed from the divide ratio, and the parity of `tout_o` flips. If a stopped timer still reacted to edges, the value preset into the counter would drift by the number of edges applied.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam logic [1:0] ADDR_LATCH  = 2'd0;
  localparam logic [1:0] ADDR_MODE   = 2'd1;
  localparam logic [1:0] ADDR_PRESET = 2'd2;

  localparam int MODE_BITS = 5;

  typedef enum logic [1:0] {
    SRC_PRESC = 2'd0,
    SRC_SLOW  = 2'd1,
    SRC_CHAIN = 2'd2,
    SRC_EVENT = 2'd3
  } src_sel_e;

  // bit4 out_en, bit3 evt_pol, bits2:1 src, bit0 stop
  typedef struct packed {
    logic     out_en;
    logic     evt_pol;
    src_sel_e src;
    logic     stop;
  } mode_t;

endpackage

// File: rtl/tmr_src_select.sv
module tmr_src_select
  import tmr_pkg::*;
(
  input  src_sel_e sel,
  input  logic     evt_pol,
  input  logic     presc,
  input  logic     slow,
  input  logic     chain,
  input  logic     evt,
  output logic     level
);

  always_comb begin
    unique case (sel)
      SRC_PRESC: level = presc;
      SRC_SLOW:  level = slow;
      SRC_CHAIN: level = chain;
      SRC_EVENT: level = evt_pol ? evt : ~evt;
      default:   level = 1'b0;
    endcase
  end

endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall_o,
  output logic rise_o
);

  localparam int NEWER = STAGES - 2;
  localparam int OLDER = STAGES - 1;

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], din};
  end

  assign fall_o = sync_q[OLDER] & ~sync_q[NEWER];
  assign rise_o = ~sync_q[OLDER] & sync_q[NEWER];

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] latch_o,
  output mode_t        mode_o,
  output logic         load_o,
  output logic         preset_o
);

  logic wr_latch, wr_mode, wr_preset;

  assign wr_latch  = wr_en && (wr_addr == ADDR_LATCH);
  assign wr_mode   = wr_en && (wr_addr == ADDR_MODE);
  assign wr_preset = wr_en && (wr_addr == ADDR_PRESET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_o <= '0;
      mode_o  <= '{out_en: 1'b0, evt_pol: 1'b0, src: SRC_PRESC, stop: 1'b1};
    end else begin
      if (wr_latch) latch_o <= wr_data;
      if (wr_mode)  mode_o  <= mode_t'(wr_data[MODE_BITS-1:0]);
    end
  end

  assign load_o   = wr_latch && mode_o.stop;
  assign preset_o = wr_preset && mode_o.stop;

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         fall,
  input  logic         rise,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] latch,
  input  logic         preset,
  input  logic         preset_val,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o,
  output logic         ff_o
);

  localparam logic [W-1:0] ALL1 = '1;
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] cnt_nxt;
  logic         pend_q;

  assign cnt_nxt = (cnt_o == ALL1) ? (latch - ONE) : (cnt_o - ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o  <= '0;
      pend_q <= 1'b0;
      ovf_o  <= 1'b0;
      ff_o   <= 1'b0;
    end else begin
      ovf_o <= 1'b0;
      if (load) begin
        cnt_o  <= load_val;
        pend_q <= 1'b0;
      end else if (run && fall) begin
        cnt_o  <= cnt_nxt;
        pend_q <= (cnt_nxt == ALL1);
      end else if (run && rise && pend_q) begin
        pend_q <= 1'b0;
        ovf_o  <= 1'b1;
        ff_o   <= ~ff_o;
      end
      if (preset) ff_o <= preset_val;
    end
  end

endmodule

// File: rtl/dctr_timer.sv
module dctr_timer
  import tmr_pkg::*;
#(
  parameter int W          = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         src_presc_i,
  input  logic         src_slow_i,
  input  logic         src_chain_i,
  input  logic         evt_pin_i,
  output logic         tout_o,
  output logic         ovf_irq_o,
  output logic [W-1:0] count_o
);

  logic [W-1:0] latch_w;
  mode_t        mode_w;
  logic         load_w, preset_w;
  logic         level_w, fall_w, rise_w;
  logic         ff_w, stop_w;

  assign stop_w = mode_w.stop;

  tmr_regs #(.W(W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .latch_o(latch_w), .mode_o(mode_w),
    .load_o(load_w), .preset_o(preset_w)
  );

  tmr_src_select sel_i (
    .sel(mode_w.src), .evt_pol(mode_w.evt_pol), .presc(src_presc_i),
    .slow(src_slow_i), .chain(src_chain_i), .evt(evt_pin_i), .level(level_w)
  );

  tmr_edge_sync #(.STAGES(SYNC_DEPTH)) sync_i (
    .clk(clk), .rst_n(rst_n), .din(level_w), .fall_o(fall_w), .rise_o(rise_w)
  );

  tmr_count_core #(.W(W)) core_i (
    .clk(clk), .rst_n(rst_n), .run(~stop_w), .fall(fall_w), .rise(rise_w),
    .load(load_w), .load_val(wr_data), .latch(latch_w),
    .preset(preset_w), .preset_val(wr_data[0]),
    .cnt_o(count_o), .ovf_o(ovf_irq_o), .ff_o(ff_w)
  );

  assign tout_o = mode_w.out_en & ff_w;

endmodule

// File: rtl/dctr_timer_chk.sv
module dctr_timer_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [1:0]   wr_addr,
  input logic         stop,
  input logic         fall,
  input logic         ovf,
  input logic         ff,
  input logic [W-1:0] cnt
);

  localparam logic [W-1:0] ALL1 = '1;

  logic latch_wr;
  assign latch_wr = wr_en && (wr_addr == 2'd0);

  p_hold_when_stopped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !latch_wr) |=> $stable(cnt));

  p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop && fall && cnt != ALL1) |=> (cnt == W'($past(cnt) - 1'b1)));

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> !ovf);

  p_ovf_at_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (cnt == ALL1));

  p_toggle_on_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (ff != $past(ff)));

endmodule

bind dctr_timer dctr_timer_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .stop(stop_w), .fall(fall_w), .ovf(ovf_irq_o), .ff(ff_w), .cnt(count_o)
);

// File: tb/dctr_timer_tb_top.sv
module dctr_timer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_SRC   = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       presc = 1'b0, slow = 1'b0, chain = 1'b0, evt = 1'b0;
  logic       tout, irq;
  logic [7:0] cnt;

  int total = 0;
  int bad = 0;
  int irq_seen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dctr_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .src_presc_i(presc), .src_slow_i(slow),
    .src_chain_i(chain), .evt_pin_i(evt), .tout_o(tout),
    .ovf_irq_o(irq), .count_o(cnt)
  );

  always @(negedge clk) if (irq) irq_seen++;

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [7:0] mode_word(bit stop, logic [1:0] sel, bit pol, bit oe);
    return {3'b000, oe, pol, sel, stop};
  endfunction

  task automatic drive(logic [1:0] sel, bit pol, bit w);
    case (sel)
      2'd0: presc = w;
      2'd1: slow  = w;
      2'd2: chain = w;
      default: evt = pol ? w : ~w;
    endcase
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(logic [1:0] sel, bit pol, int k);
    for (int i = 0; i < k; i++) begin
      drive(sel, pol, 1'b1); wait_clk(HALF_SRC);
      drive(sel, pol, 1'b0); wait_clk(HALF_SRC);
    end
  endtask

  function automatic int exp_count(int n, int k);
    int j;
    if (k <= n) return n - k;
    j = (k - (n + 1)) % (n + 1);
    return (j == 0) ? 255 : n - j;
  endfunction

  task automatic run_case(logic [1:0] sel, bit pol, int n, int k, string tag);
    wr(2'd1, mode_word(1'b1, sel, pol, 1'b1));
    wr(2'd0, 8'(n));
    wr(2'd2, 8'h00);
    drive(sel, pol, 1'b0); wait_clk(HALF_SRC);
    check({tag, " R2 load while stopped"}, cnt, n);
    wr(2'd1, mode_word(1'b0, sel, pol, 1'b1));
    irq_seen = 0;
    pulses(sel, pol, k);
    drive(sel, pol, 1'b1); wait_clk(HALF_SRC);
    check({tag, " R3 R4 count"}, cnt, exp_count(n, k));
    check({tag, " R5 overflows"}, irq_seen, k / (n + 1));
    check({tag, " R7 toggle parity"}, tout, (k / (n + 1)) % 2);
    wr(2'd1, mode_word(1'b1, sel, pol, 1'b1));
    drive(sel, pol, 1'b0); wait_clk(HALF_SRC);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
    check("R1 count", cnt, 0);
    check("R1 tout", tout, 0);
    check("R1 irq", irq_seen, 0);

    // R4 R5 R9: sweep latch values on source 0
    for (int n = 0; n < 8; n++) run_case(2'd0, 1'b0, n, 20, "src0");
    run_case(2'd1, 1'b0, 3, 17, "R9 slow");
    run_case(2'd2, 1'b0, 2, 13, "R9 chain");
    run_case(2'd3, 1'b1, 4, 16, "R10 pol1");
    run_case(2'd3, 1'b0, 5, 19, "R10 pol0");

    // R6: stopped timer ignores edges
    wr(2'd1, mode_word(1'b1, 2'd0, 1'b0, 1'b1));
    wr(2'd0, 8'd7);
    irq_seen = 0;
    pulses(2'd0, 1'b0, 9);
    check("R6 count held", cnt, 7);
    check("R6 no overflow", irq_seen, 0);

    // R8 / R7: preset and output gating
    wr(2'd2, 8'h01);
    check("R8 preset while stopped", tout, 1);
    wr(2'd1, mode_word(1'b1, 2'd0, 1'b0, 1'b0));
    check("R7 output disabled", tout, 0);
    wr(2'd1, mode_word(1'b1, 2'd0, 1'b0, 1'b1));
    wr(2'd2, 8'h00);
    check("R8 preset zero", tout, 0);

    // running: latency, latch write, preset ignored
    wr(2'd0, 8'd9);
    wr(2'd1, mode_word(1'b0, 2'd0, 1'b0, 1'b1));
    pulses(2'd0, 1'b0, 3);
    check("R3 after three edges", cnt, 6);
    presc = 1'b1; wait_clk(HALF_SRC);
    presc = 1'b0;
    @(negedge clk);
    check("R11 not after one edge", cnt, 6);
    @(negedge clk);
    check("R11 after two edges", cnt, 5);
    wait_clk(HALF_SRC);
    wr(2'd0, 8'd2);
    check("R2 running latch write", cnt, 5);
    wr(2'd2, 8'h01);
    check("R8 preset ignored while running", tout, 0);
    pulses(2'd0, 1'b0, 7);
    check("R4 reload uses new latch", cnt, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule